// File: doc/BRIEF.md
# Retention Configuration Key Sequencer

This block drives a fixed key sequence of ordinary memory accesses that selects how much of a pseudo-static memory keeps its contents once the chip is put into its low-power state. It sits in front of the memory access controller. A single start pulse, together with a 2-bit retention mode code, launches six accesses:

- one read of the top word;
- four writes to that same word;
- one closing read from an address that depends on the chosen mode.

The memory only recognises the key if its chip returns to standby between accesses. The sequencer therefore keeps its request line low for a programmable number of cycles after every access.

The write data follows a fixed pattern:

- The first two writes echo back the value returned by the opening read.
- The next write is all zeros.
- The last write carries the mode code.

For every write, the access controller reports back the word it actually put on the bus. The sequencer compares that echo with what it asked for. A mismatch means the memory would see a broken key, so the sequencer drops the rest of the sequence and raises an abort flag. If the corrupted word is one of the two read-back echoes, it also raises an echo error flag. A clean run ends with a one-cycle done pulse.

Top module: `rcfg_sequencer`

## Requirements
- R1: After an accepted start, the block issues exactly six accesses. In order their directions are read, write, write, write, write, read; `req_write_o` is 1 for a write.
- R2: Accesses one to five use the all-ones address (1FFFFFh at the default width).
- R3: The second and third accesses write the data returned by the first access. The fourth writes 0000h. The fifth writes the mode code in bits 1..0 with zeros above. The codes are 11 for deep power-down, 10 for 4 Mbit, 01 for 8 Mbit and 00 for 16 Mbit retention.
- R4: The sixth access reads an address whose bits 18..0 are all ones. Bit 20 is mode bit 0 and bit 19 is mode bit 1, which gives 1FFFFFh, 0FFFFFh, 17FFFFh and 07FFFFh for codes 11, 10, 01 and 00.
- R5: A request holds its address, direction and data stable until `req_ack_i`. The request is low in the cycle after the acknowledge.
- R6: The request line stays low for at least GAP_CYC cycles after each acknowledge.
- R7: `done_o` pulses high for exactly one cycle. That cycle comes GAP_CYC+1 cycles after the sixth acknowledge, with `busy_o` already low.
- R8: A start while busy is ignored. The mode in use is not changed and the sequence does not restart.
- R9: A write echo on the second or third access that differs from the first read value sets both `echo_err_o` and `abort_o`. After that, no further access is issued, no done pulse follows, and `busy_o` falls after the standby gap.
- R10: A write echo on the fourth or fifth access that differs from the requested data sets `abort_o` only, and stops the sequence in the same way.
- R11: Out of reset, `busy_o`, `req_valid_o`, `done_o`, `abort_o` and `echo_err_o` are all low.
- R12: `abort_o` and `echo_err_o` hold their value until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run the key sequence |
| mode_i | input | 2 | Retention mode code, sampled with an accepted start |
| req_valid_o | output | 1 | Access request to the memory controller |
| req_write_o | output | 1 | Access direction, 1 = write |
| req_addr_o | output | AW | Access word address |
| req_wdata_o | output | DW | Write data |
| req_ack_i | input | 1 | Controller has completed the current access |
| rsp_data_i | input | DW | Read data, or echo of the driven write word, valid with ack |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at successful completion |
| abort_o | output | 1 | Sequence stopped on a bad echo |
| echo_err_o | output | 1 | Read-back echo did not match the first read value |

## Verification
If the step counter is off by one, the first affected request shows the wrong direction, address or data. That request appears on the port as soon as the current standby gap ends, and the bench compares every request field access by access. A corrupted captured key or mode register shows up on the second, fifth or sixth request. A broken gap timer shows up as a request that rises too early, or as a done pulse that is displaced from its exact cycle. Abort handling is checked by corrupting a single echo: the flags must appear the cycle after that acknowledge, and the request line must then stay silent.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;

  localparam int unsigned STEP_W = 3;
  localparam logic [STEP_W-1:0] LAST_STEP = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_e;

  // what happens when the standby gap ends
  typedef enum logic [1:0] {
    EX_NEXT = 2'd0,
    EX_DONE = 2'd1,
    EX_STOP = 2'd2
  } gap_exit_e;

endpackage

// File: rtl/rcfg_step_gen.sv
module rcfg_step_gen
  import rcfg_pkg::*;
#(
  parameter int unsigned AW = 21,
  parameter int unsigned DW = 16
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [1:0]        mode_i,
  input  logic [DW-1:0]     key_i,
  output logic              wr_o,
  output logic [AW-1:0]     addr_o,
  output logic [DW-1:0]     wdata_o
);

  localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};

  logic [AW-1:0] fin_addr;
  logic [DW-1:0] cfg_word;

  // mode bits land in the two top address bits, swapped
  assign fin_addr = {mode_i[0], mode_i[1], {(AW-2){1'b1}}};
  assign cfg_word = {{(DW-2){1'b0}}, mode_i};

  always_comb begin
    wr_o    = 1'b0;
    addr_o  = TOP_ADDR;
    wdata_o = '0;
    unique case (step_i)
      3'd0: begin
        wr_o = 1'b0;
      end
      3'd1, 3'd2: begin
        wr_o    = 1'b1;
        wdata_o = key_i;
      end
      3'd3: begin
        wr_o    = 1'b1;
        wdata_o = '0;
      end
      3'd4: begin
        wr_o    = 1'b1;
        wdata_o = cfg_word;
      end
      3'd5: begin
        wr_o   = 1'b0;
        addr_o = fin_addr;
      end
      default: begin
        wr_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/rcfg_gap_timer.sv
module rcfg_gap_timer #(
  parameter int unsigned GAP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);

  localparam int unsigned CW = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC);
  localparam logic [CW-1:0] CNT_END = CW'(GAP_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (run_i && (cnt_q != CNT_END)) cnt_d = cnt_q + 1'b1;
    else                             cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = run_i && (cnt_q == CNT_END);

endmodule

// File: rtl/rcfg_ctrl.sv
module rcfg_ctrl
  import rcfg_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              req_ack_i,
  input  logic [DW-1:0]     rsp_data_i,
  input  logic              step_wr_i,
  input  logic [DW-1:0]     step_wdata_i,
  input  logic              gap_last_i,
  output logic [STEP_W-1:0] step_o,
  output logic [1:0]        mode_o,
  output logic [DW-1:0]     key_o,
  output logic              req_valid_o,
  output logic              gap_run_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              abort_o,
  output logic              echo_err_o
);

  seq_state_e        state_q, state_d;
  gap_exit_e         exit_q, exit_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [1:0]        mode_q;
  logic [DW-1:0]     key_q;
  logic              done_q, done_d;
  logic              abort_q, abort_d;
  logic              err_q, err_d;

  logic accept_start;
  logic acked;
  logic key_en;
  logic echo_bad;

  assign accept_start = (state_q == ST_IDLE) && start_i;
  assign acked        = (state_q == ST_REQ) && req_ack_i;
  assign key_en       = acked && (step_q == 3'd0);
  assign echo_bad     = acked && step_wr_i && (rsp_data_i != step_wdata_i);

  always_comb begin
    state_d = state_q;
    exit_d  = exit_q;
    step_d  = step_q;
    abort_d = abort_q;
    err_d   = err_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_REQ;
          step_d  = '0;
          exit_d  = EX_NEXT;
          abort_d = 1'b0;
          err_d   = 1'b0;
        end
      end
      ST_REQ: begin
        if (req_ack_i) begin
          state_d = ST_GAP;
          exit_d  = (step_q == LAST_STEP) ? EX_DONE : EX_NEXT;
          if (echo_bad) begin
            exit_d  = EX_STOP;
            abort_d = 1'b1;
            if (step_q <= 3'd2) err_d = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (gap_last_i) begin
          unique case (exit_q)
            EX_NEXT: begin
              state_d = ST_REQ;
              step_d  = step_q + 1'b1;
            end
            EX_DONE: begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
            default: state_d = ST_IDLE;
          endcase
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      exit_q  <= EX_NEXT;
      step_q  <= '0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      exit_q  <= exit_d;
      step_q  <= step_d;
      done_q  <= done_d;
      abort_q <= abort_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            mode_q <= '0;
    else if (accept_start) mode_q <= mode_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      key_q <= '0;
    else if (key_en) key_q <= rsp_data_i;
  end

  assign step_o      = step_q;
  assign mode_o      = mode_q;
  assign key_o       = key_q;
  assign req_valid_o = (state_q == ST_REQ);
  assign gap_run_o   = (state_q == ST_GAP);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign abort_o     = abort_q;
  assign echo_err_o  = err_q;

endmodule

// File: rtl/rcfg_sequencer.sv
module rcfg_sequencer
  import rcfg_pkg::*;
#(
  parameter int unsigned AW      = 21,
  parameter int unsigned DW      = 16,
  parameter int unsigned GAP_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  output logic          req_valid_o,
  output logic          req_write_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_wdata_o,
  input  logic          req_ack_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          abort_o,
  output logic          echo_err_o
);

  logic [STEP_W-1:0] step_w;
  logic [1:0]        mode_w;
  logic [DW-1:0]     key_w;
  logic              gap_run_w;
  logic              gap_last_w;
  logic              wr_w;
  logic [AW-1:0]     addr_w;
  logic [DW-1:0]     wdata_w;

  rcfg_ctrl #(.DW(DW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mode_i       (mode_i),
    .req_ack_i    (req_ack_i),
    .rsp_data_i   (rsp_data_i),
    .step_wr_i    (wr_w),
    .step_wdata_i (wdata_w),
    .gap_last_i   (gap_last_w),
    .step_o       (step_w),
    .mode_o       (mode_w),
    .key_o        (key_w),
    .req_valid_o  (req_valid_o),
    .gap_run_o    (gap_run_w),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .abort_o      (abort_o),
    .echo_err_o   (echo_err_o)
  );

  rcfg_step_gen #(.AW(AW), .DW(DW)) u_step (
    .step_i  (step_w),
    .mode_i  (mode_w),
    .key_i   (key_w),
    .wr_o    (wr_w),
    .addr_o  (addr_w),
    .wdata_o (wdata_w)
  );

  rcfg_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (gap_run_w),
    .last_o (gap_last_w)
  );

  assign req_write_o = wr_w;
  assign req_addr_o  = addr_w;
  assign req_wdata_o = wdata_w;

endmodule

// File: rtl/rcfg_checker.sv
module rcfg_checker #(
  parameter int unsigned AW      = 21,
  parameter int unsigned DW      = 16,
  parameter int unsigned GAP_CYC = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid_o,
  input logic          req_write_o,
  input logic [AW-1:0] req_addr_o,
  input logic [DW-1:0] req_wdata_o,
  input logic          req_ack_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          abort_o,
  input logic          echo_err_o,
  input logic [2:0]    step_w
);

  int unsigned low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_cnt <= GAP_CYC;
    else if (req_valid_o)      low_cnt <= 0;
    else if (low_cnt < GAP_CYC) low_cnt <= low_cnt + 1;
  end

  a_r1_direction: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_write_o == ((step_w >= 3'd1) && (step_w <= 3'd4))));

  a_r2_top_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && (step_w != 3'd5)) |-> (&req_addr_o));

  a_r4_final_low_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && (step_w == 3'd5)) |-> (&req_addr_o[AW-3:0]));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ack_i) |=> (req_valid_o && $stable(req_addr_o)
                                     && $stable(req_wdata_o) && $stable(req_write_o)));

  a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_ack_i) |=> !req_valid_o);

  a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid_o) |-> (low_cnt >= GAP_CYC));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !req_valid_o));

  a_r9_err_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    echo_err_o |-> abort_o);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !req_valid_o);

endmodule

bind rcfg_sequencer rcfg_checker #(.AW(AW), .DW(DW), .GAP_CYC(GAP_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid_o (req_valid_o),
  .req_write_o (req_write_o),
  .req_addr_o  (req_addr_o),
  .req_wdata_o (req_wdata_o),
  .req_ack_i   (req_ack_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .abort_o     (abort_o),
  .echo_err_o  (echo_err_o),
  .step_w      (step_w)
);

// File: tb/sim_rcfg_sequencer.sv
module sim_rcfg_sequencer;

  localparam int CLK_P = 10;
  localparam int AW    = 21;
  localparam int DW    = 16;
  localparam int GAP   = 4;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [1:0]    mode_i;
  logic          req_valid_o;
  logic          req_write_o;
  logic [AW-1:0] req_addr_o;
  logic [DW-1:0] req_wdata_o;
  logic          req_ack_i;
  logic [DW-1:0] rsp_data_i;
  logic          busy_o;
  logic          done_o;
  logic          abort_o;
  logic          echo_err_o;

  int n_tests;
  int n_fail;

  rcfg_sequencer #(.AW(AW), .DW(DW), .GAP_CYC(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .req_valid_o(req_valid_o), .req_write_o(req_write_o),
    .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o),
    .req_ack_i(req_ack_i), .rsp_data_i(rsp_data_i),
    .busy_o(busy_o), .done_o(done_o), .abort_o(abort_o), .echo_err_o(echo_err_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run hung, act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] fin_addr(input logic [1:0] md);
    case (md)
      2'b11:   return 21'h1FFFFF;
      2'b10:   return 21'h0FFFFF;
      2'b01:   return 21'h17FFFF;
      default: return 21'h07FFFF;
    endcase
  endfunction

  task automatic pulse_start(input logic [1:0] md);
    start_i = 1'b1;
    mode_i  = md;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // bad: index of the access whose echo is corrupted, -1 for none
  // mid: issue a second start with another mode while the third access waits
  task automatic run_seq(input logic [1:0] md, input logic [15:0] rd0,
                         input int bad, input bit mid);
    logic [DW-1:0] expw;
    pulse_start(md);
    chk(!abort_o && !echo_err_o, "R12", "flags cleared on start",
        {abort_o, echo_err_o}, 0);
    for (int s = 0; s < 6; s++) begin
      int w;
      w = 0;
      while (!req_valid_o && w < 200) begin
        @(negedge clk);
        w++;
      end
      if (s > 0) chk((w + 1) >= GAP, "R6", "standby gap length", w + 1, GAP);
      chk(req_write_o == (s >= 1 && s <= 4), "R1", "access direction", req_write_o, s);
      if (s < 5) chk(req_addr_o == 21'h1FFFFF, "R2", "top address", req_addr_o, 21'h1FFFFF);
      else       chk(req_addr_o == fin_addr(md), "R4", "final read address", req_addr_o, fin_addr(md));
      expw = (s == 1 || s == 2) ? rd0 : (s == 4) ? {14'b0, md} : 16'h0000;
      if (s >= 1 && s <= 4) chk(req_wdata_o == expw, "R3", "write data", req_wdata_o, expw);
      if (mid && s == 2) begin
        pulse_start(~md);
        chk(req_valid_o && req_write_o && req_addr_o == 21'h1FFFFF, "R8",
            "start while busy leaves request", req_addr_o, 21'h1FFFFF);
      end
      @(negedge clk);
      chk(req_valid_o && req_wdata_o == expw, "R5", "request held until ack",
          req_wdata_o, expw);
      req_ack_i  = 1'b1;
      rsp_data_i = (s == 0) ? rd0 : (s == 5) ? 16'h5A5A :
                   (s == bad) ? (req_wdata_o ^ 16'h0100) : req_wdata_o;
      @(negedge clk);
      req_ack_i = 1'b0;
      chk(!req_valid_o, "R5", "request low after ack", req_valid_o, 0);
      if (s == bad) begin
        bit quiet;
        bit exp_err;
        exp_err = (bad <= 2);
        if (exp_err) chk(abort_o && echo_err_o, "R9", "echo error flags",
                         {abort_o, echo_err_o}, 3);
        else         chk(abort_o && !echo_err_o, "R10", "abort only",
                         {abort_o, echo_err_o}, 2);
        quiet = 1'b1;
        for (int k = 0; k < GAP + 3; k++) begin
          @(negedge clk);
          if (req_valid_o || done_o) quiet = 1'b0;
        end
        chk(quiet && !busy_o, exp_err ? "R9" : "R10", "no access or done after abort",
            {quiet, busy_o}, 2);
        chk(abort_o == 1'b1 && echo_err_o == exp_err, "R12", "flags held after abort",
            {abort_o, echo_err_o}, {1'b1, exp_err});
        return;
      end
    end
    begin
      int k;
      int hit;
      hit = -1;
      for (k = 1; k <= GAP + 3; k++) begin
        if (done_o && hit < 0) hit = k;
        if (k <= GAP) chk(!req_valid_o, "R6", "low after last access", req_valid_o, 0);
        @(negedge clk);
      end
      chk(hit == GAP + 1, "R7", "done cycle after last ack", hit, GAP + 1);
      chk(!done_o && !busy_o, "R7", "single done pulse", {done_o, busy_o}, 0);
    end
  endtask

  task automatic t_reset;
    chk(!busy_o && !req_valid_o && !done_o && !abort_o && !echo_err_o, "R11",
        "reset state", {busy_o, req_valid_o, done_o, abort_o, echo_err_o}, 0);
  endtask

  task automatic t_modes;
    run_seq(2'b11, 16'hBEEF, -1, 1'b0);
    run_seq(2'b10, 16'h1234, -1, 1'b0);
    run_seq(2'b01, 16'h0000, -1, 1'b0);
    run_seq(2'b00, 16'hFFFF, -1, 1'b0);
  endtask

  task automatic t_busy_start;
    run_seq(2'b10, 16'hC3C3, -1, 1'b1);
  endtask

  task automatic t_echo_err;
    run_seq(2'b01, 16'h7E81, 1, 1'b0);
    run_seq(2'b11, 16'h00A5, -1, 1'b0);
    run_seq(2'b00, 16'h4411, 2, 1'b0);
  endtask

  task automatic t_cfg_abort;
    run_seq(2'b10, 16'h9999, 3, 1'b0);
    run_seq(2'b01, 16'h2468, 4, 1'b0);
    run_seq(2'b11, 16'h1357, -1, 1'b0);
  endtask

  initial begin
    n_tests    = 0;
    n_fail     = 0;
    rst_n      = 1'b0;
    start_i    = 1'b0;
    mode_i     = 2'b00;
    req_ack_i  = 1'b0;
    rsp_data_i = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_modes;
    t_busy_start;
    t_echo_err;
    t_cfg_abort;
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule